// File: doc/BRIEF.md
# Debounced 4x4 Matrix Keypad Scanner

This block reads a sixteen-key switch matrix wired to a single 8-bit port. Four column lines are outputs and four row lines are inputs that idle high through external pull-ups. The scanner pulls one column low at a time and rotates that zero through all four columns. Each column is held for a short settling period. The rows are then sampled through a two-stage synchronizer. A row that reads low means a key joins that row to the active column.

On such a hit the scanner stops rotating and keeps the column. It then requires the row to stay low for a full debounce window before it accepts the key. When it accepts the key, it publishes the key code together with a one-cycle strobe and raises a held flag. The release is filtered with the same window. Only after the release is confirmed does scanning resume, starting on the next column. The window length is given in microseconds and converted to clock cycles from the clock frequency. The default is 10 ms, which is longer than the contact bounce of mechanical keys (up to about 5 ms).

Top module: `keypad_scanner`

## Requirements
- R1: While reset is asserted and just after it, `col_drive_n` is 4'b1110, `key_valid` is 0, `key_held` is 0 and `key_code` is 0.
- R2: With no key pressed, exactly one bit of `col_drive_n` is 0 at any time. Each pattern lasts SETTLE_CYCLES cycles. The zero then moves to the next higher bit, wrapping from bit 3 to bit 0, so the order is 1110, 1101, 1011, 0111.
- R3: The column index is the position of the 0 in `col_drive_n` (bit 0 is port line 4). The row index is the position of the low bit in `row_sense_n`. The reported `key_code` is 4*column + row.
- R4: A press is accepted only after the sensed row has been low for DB_CYCLES consecutive cycles, where DB_CYCLES = CLK_FREQ_HZ/1,000,000 * DEBOUNCE_US. `key_valid` appears between DB_CYCLES+2 and DB_CYCLES+4*SETTLE_CYCLES+6 cycles after the key closes.
- R5: Low bursts shorter than DB_CYCLES (contact bounce) never produce `key_valid` or `key_held`.
- R6: After the key opens, `key_held` stays 1 until the row has been high for DB_CYCLES consecutive cycles. An opening shorter than that is ignored.
- R7: `key_valid` is a single-cycle pulse, issued once per accepted press and never repeated while the key stays down. `key_held` is 1 from the strobe until the release is confirmed.
- R8: From detection until the release is confirmed, `col_drive_n` stays frozen on the key's column. When `key_held` falls, the drive has already moved to the next column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| col_drive_n | output | 4 | Column outputs (port lines 7..4 as bits 3..0); the active column is low |
| row_sense_n | input | 4 | Row inputs (port lines 3..0), pulled up; low when a key closes |
| key_code | output | 4 | Code of the last accepted key, 4*column + row |
| key_valid | output | 1 | One-cycle strobe per accepted press |
| key_held | output | 1 | High while an accepted key is down or its release is being confirmed |

## Verification
The row inputs pass through two synchronizer flops, so nothing is decided on them until two cycles after they change. The bench therefore checks timing against windows derived from DB_CYCLES and SETTLE_CYCLES rather than against single cycles. The strobe must land between DB_CYCLES+2 and DB_CYCLES+4*SETTLE_CYCLES+6 cycles after closure, depending on where the scan stood. The fall of `key_held` must land between DB_CYCLES+1 and DB_CYCLES+6 cycles after opening. The bench sweeps all sixteen keys, and it also checks the column dwell and rotation order cycle by cycle. Every sample is taken on the falling clock edge, after the registered outputs have settled.

// File: rtl/keypad_pkg.sv
// Shared types for the keypad scanner.
// Assumes: included first in compile order.
package keypad_pkg;

    // Scanner control states.
    typedef enum logic [1:0] {
        KP_SCAN     = 2'd0,  // rotating the low column
        KP_PRESS_DB = 2'd1,  // column frozen, filtering a closure
        KP_HELD     = 2'd2,  // key accepted and down
        KP_REL_DB   = 2'd3   // filtering an opening
    } kp_state_t;

endpackage

// File: rtl/keypad_sync.sv
// Two-flop synchronizer for asynchronous pulled-up inputs.
// Assumes: inputs idle high, so reset loads all ones.
module keypad_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    // Two register stages to resolve metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '1;
            sync_out <= '1;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/keypad_timer.sv
// Saturating cycle counter. done is high when LIMIT cycles have been counted.
// Assumes: LIMIT >= 1; clr takes priority over en.
module keypad_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == LAST);

    // Count enabled cycles up to LAST, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (en && !done)
            cnt <= cnt + 1'b1;
    end

    assert_timer_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/keypad_col_drive.sv
// Decodes the active column index into active-low column drive lines.
// Assumes: col_idx < COLS.
module keypad_col_drive #(
    parameter int COLS = 4
) (
    input  logic [$clog2(COLS)-1:0] col_idx,
    output logic [COLS-1:0]         drive_n
);
    localparam int IW = $clog2(COLS);

    for (genvar i = 0; i < COLS; i++) begin : g_col
        // Line i is low only when it is the selected column.
        assign drive_n[i] = (col_idx != IW'(i));
    end
endmodule

// File: rtl/keypad_scanner.sv
// Walking-zero matrix keypad scanner with press and release debounce.
// Assumes: SETTLE_CYCLES >= 3 so that the synchronized rows reflect the
// current column before sampling; one key pressed at a time (lowest row wins).
module keypad_scanner
    import keypad_pkg::*;
#(
    parameter int CLK_FREQ_HZ   = 50_000_000,
    parameter int DEBOUNCE_US   = 10_000,
    parameter int SETTLE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [3:0] col_drive_n,
    input  logic [3:0] row_sense_n,
    output logic [3:0] key_code,
    output logic       key_valid,
    output logic       key_held
);
    localparam int COLS      = 4;
    localparam int ROWS      = 4;
    localparam int DB_CYCLES = (CLK_FREQ_HZ / 1_000_000) * DEBOUNCE_US;
    localparam int CIW       = $clog2(COLS);
    localparam int RIW       = $clog2(ROWS);
    localparam int KW        = $clog2(COLS * ROWS);

    kp_state_t         state;
    logic [CIW-1:0]    col_q;
    logic [RIW-1:0]    row_q;
    logic [ROWS-1:0]   row_s;
    logic [RIW-1:0]    low_row;
    logic              any_low;
    logic              row_hi;
    logic              settle_done, settle_clr;
    logic              db_done, db_clr;

    keypad_sync #(.WIDTH(ROWS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(row_sense_n), .sync_out(row_s)
    );

    keypad_col_drive #(.COLS(COLS)) u_cols (
        .col_idx(col_q), .drive_n(col_drive_n)
    );

    keypad_timer #(.LIMIT(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst_n(rst_n), .clr(settle_clr), .en(1'b1), .done(settle_done)
    );

    keypad_timer #(.LIMIT(DB_CYCLES)) u_debounce (
        .clk(clk), .rst_n(rst_n), .clr(db_clr), .en(1'b1), .done(db_done)
    );

    // Lowest-numbered row reading low on the active column.
    always_comb begin
        low_row = '0;
        any_low = 1'b0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (!row_s[i]) begin
                low_row = RIW'(i);
                any_low = 1'b1;
            end
        end
    end

    // Level of the locked row: high means the key is open.
    assign row_hi = row_s[row_q];

    // Settle timer restarts per column; debounce timer restarts on any level change.
    always_comb begin
        settle_clr = (state != KP_SCAN) || settle_done;
        db_clr     = (state == KP_SCAN) || (state == KP_HELD)
                   || (state == KP_PRESS_DB && row_hi)
                   || (state == KP_REL_DB && !row_hi);
    end

    // Scan, lock, debounce and release sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= KP_SCAN;
            col_q     <= '0;
            row_q     <= '0;
            key_code  <= '0;
            key_valid <= 1'b0;
        end else begin
            key_valid <= 1'b0;
            unique case (state)
                KP_SCAN: if (settle_done) begin
                    if (any_low) begin
                        state <= KP_PRESS_DB;
                        row_q <= low_row;
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                KP_PRESS_DB: begin
                    if (row_hi) begin
                        state <= KP_SCAN;
                    end else if (db_done) begin
                        state     <= KP_HELD;
                        key_valid <= 1'b1;
                        key_code  <= KW'(col_q) * KW'(ROWS) + KW'(row_q);
                    end
                end
                KP_HELD: if (row_hi) state <= KP_REL_DB;
                KP_REL_DB: begin
                    if (!row_hi) begin
                        state <= KP_HELD;
                    end else if (db_done) begin
                        state <= KP_SCAN;
                        col_q <= col_q + 1'b1;
                    end
                end
                default: state <= KP_SCAN;
            endcase
        end
    end

    assign key_held = (state == KP_HELD) || (state == KP_REL_DB);

    assert_one_col_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_drive_n) == COLS - 1);

    assert_valid_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> key_held);

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid);

    assert_col_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (key_held && $past(key_held)) |-> $stable(col_drive_n));
endmodule

// File: tb/keypad_scanner_test.sv
// Self-checking bench: scan order, all sixteen keys, bounce and release filtering.
module keypad_scanner_test;
    localparam int CLK_HZ = 1_000_000;
    localparam int DB_US  = 20;
    localparam int SET    = 4;
    localparam int DB     = (CLK_HZ / 1_000_000) * DB_US;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] col_drive_n;
    logic [3:0] row_sense_n;
    logic [3:0] key_code;
    logic       key_valid;
    logic       key_held;

    logic       key_on = 1'b0;
    logic [1:0] key_c  = '0;
    logic [1:0] key_r  = '0;

    int checks = 0;
    int errors = 0;
    int valid_cnt = 0;
    logic [3:0] code_seen = '0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    keypad_scanner #(.CLK_FREQ_HZ(CLK_HZ), .DEBOUNCE_US(DB_US), .SETTLE_CYCLES(SET)) uut (
        .clk(clk), .rst_n(rst_n), .col_drive_n(col_drive_n), .row_sense_n(row_sense_n),
        .key_code(key_code), .key_valid(key_valid), .key_held(key_held)
    );

    // Matrix model: a closed key pulls its row low while its column is driven low.
    always_comb begin
        row_sense_n = 4'hF;
        if (key_on && !col_drive_n[key_c]) row_sense_n[key_r] = 1'b0;
    end

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && key_valid) begin
            valid_cnt++;
            code_seen = key_code;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150_000 && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150_000);
            report();
        end
    end

    function automatic logic [3:0] rotl(input logic [3:0] v);
        return {v[2:0], v[3]};
    endfunction

    // Close a key, verify acceptance, hold, open, verify release and resume.
    task automatic press_key(input int c, input int r);
        int lat;
        int n;
        logic [3:0] locked;
        valid_cnt = 0;
        key_c = 2'(c);
        key_r = 2'(r);
        key_on = 1'b1;
        lat = 0;
        while (valid_cnt == 0 && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        chk(lat >= DB + 2 && lat <= DB + 4 * SET + 6, "R4 latency", lat, DB);
        chk(code_seen == 4'(c * 4 + r), "R3 key code", int'(code_seen), c * 4 + r);
        chk(key_held == 1'b1, "R7 held after strobe", int'(key_held), 1);
        locked = ~(4'b0001 << c);
        chk(col_drive_n == locked, "R8 column locked", int'(col_drive_n), int'(locked));
        repeat (30) @(negedge clk);
        chk(valid_cnt == 1, "R7 no repeat", valid_cnt, 1);
        chk(col_drive_n == locked, "R8 column frozen", int'(col_drive_n), int'(locked));
        key_on = 1'b0;
        repeat (DB / 2) @(negedge clk);
        chk(key_held == 1'b1, "R6 held during release filter", int'(key_held), 1);
        n = DB / 2;
        while (key_held && n < DB + 40) begin
            @(negedge clk);
            n++;
        end
        chk(n >= DB + 1 && n <= DB + 6, "R6 release time", n, DB);
        chk(col_drive_n == rotl(locked), "R8 scan resumes", int'(col_drive_n), int'(rotl(locked)));
        chk(valid_cnt == 1, "R7 one strobe per press", valid_cnt, 1);
    endtask

    initial begin
        logic [3:0] prev;
        int dwell;
        bit first;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(col_drive_n == 4'b1110, "R1 reset column", int'(col_drive_n), 14);
        chk(key_valid == 1'b0, "R1 reset strobe", int'(key_valid), 0);
        chk(key_held == 1'b0, "R1 reset held", int'(key_held), 0);
        chk(key_code == 4'd0, "R1 reset code", int'(key_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(col_drive_n == 4'b1110, "R1 first column after reset", int'(col_drive_n), 14);

        // R2: walking zero order and dwell with no key.
        prev = col_drive_n;
        dwell = 1;
        first = 1'b1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            chk($countones(col_drive_n) == 3, "R2 single low column", int'(col_drive_n), 3);
            if (col_drive_n != prev) begin
                chk(col_drive_n == rotl(prev), "R2 rotation order", int'(col_drive_n), int'(rotl(prev)));
                if (!first) chk(dwell == SET, "R2 dwell", dwell, SET);
                first = 1'b0;
                dwell = 1;
            end else begin
                dwell++;
            end
            prev = col_drive_n;
        end

        // R3/R4/R7/R8: every key in the matrix.
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                press_key(c, r);

        // R5: bounce bursts shorter than the window.
        valid_cnt = 0;
        key_c = 2'd1;
        key_r = 2'd2;
        for (int i = 0; i < 6; i++) begin
            key_on = 1'b1;
            repeat (8) @(negedge clk);
            chk(key_held == 1'b0, "R5 no hold during bounce", int'(key_held), 0);
            key_on = 1'b0;
            repeat (4) @(negedge clk);
        end
        key_on = 1'b1;
        repeat (DB - 5) @(negedge clk);
        key_on = 1'b0;
        repeat (DB) @(negedge clk);
        chk(valid_cnt == 0, "R5 bounce rejected", valid_cnt, 0);
        chk(key_held == 1'b0, "R5 not held after bounce", int'(key_held), 0);

        // R6: short openings while held are ignored.
        valid_cnt = 0;
        key_c = 2'd2;
        key_r = 2'd1;
        key_on = 1'b1;
        repeat (DB + 4 * SET + 10) @(negedge clk);
        chk(valid_cnt == 1, "R4 press accepted", valid_cnt, 1);
        for (int i = 0; i < 4; i++) begin
            key_on = 1'b0;
            repeat (6) @(negedge clk);
            chk(key_held == 1'b1, "R6 glitch ignored", int'(key_held), 1);
            key_on = 1'b1;
            repeat (6) @(negedge clk);
        end
        chk(valid_cnt == 1, "R7 no strobe on re-close", valid_cnt, 1);
        chk(key_code == 4'd9, "R3 code kept", int'(key_code), 9);
        key_on = 1'b0;
        repeat (DB + 10) @(negedge clk);
        chk(key_held == 1'b0, "R6 release confirmed", int'(key_held), 0);

        report();
    end
endmodule